// File: doc/BRIEF.md
# Interrupt and Frequency-Test Pin Arbiter

A real-time clock shares one active-low, open-drain output pin between three uses. The pin can carry a watchdog interrupt, an alarm interrupt, or a square wave at 512 Hz that is used to measure the oscillator during calibration. This block chooses which of these drives the pin and produces one enable signal, `pin_pull_low`. When that signal is high the pad pulls the pin low. When it is low an external resistor pulls the pin high.

The square wave is produced only when four register conditions all hold:
- the clock is running;
- the test bit is set;
- alarm signalling on the pin is off;
- the watchdog is either steered to the reset pin or fully cleared.

The block flips its output on every pulse of a 1024 Hz tick, which gives 512 Hz at 50% duty. Trimming of the clock rate does not reach this path.

An interrupt routed to the pin always takes priority over the test wave and holds the pin steadily low. The test bit is stored inside the block. A power-fail indication clears it, and software sets or clears it through a write strobe.

Top module: `irqft_pin_arbiter`

## Requirements
- R1: After a synchronous reset, `pin_pull_low` is 0 and the stored test bit is 0.
- R2: While the test wave is granted, `pin_pull_low` inverts one cycle after each cycle in which `tick_1k` is 1, and stays unchanged after a cycle in which `tick_1k` is 0.
- R3: When `stop_bit` is 1 and no interrupt is routed to the pin, `pin_pull_low` is 0 on the next cycle.
- R4: When `afe_bit` is 1 and `alarm_irq` is 0, the test wave is denied and `pin_pull_low` is 0.
- R5: The test wave is denied when `wd_reg` is nonzero and its most significant bit (steering, 0 = pin) is 0. It is allowed when `wd_reg` is all zeros or its most significant bit is 1.
- R6: When `wdog_irq` is 1 and the steering bit of `wd_reg` is 0, `pin_pull_low` is 1 on the next cycle, without toggling, even if the test wave is otherwise granted.
- R7: When `alarm_irq` and `afe_bit` are both 1, `pin_pull_low` is 1 on the next cycle, without toggling.
- R8: When `wdog_irq` is 1 and the steering bit is 1, the watchdog request has no effect on `pin_pull_low`.
- R9: `power_fail` clears the stored test bit on the next cycle and takes priority over a simultaneous write that sets it (`ft_wr`=1, `ft_wdata`=1).
- R10: When no interrupt is routed to the pin and the test wave is not granted, `pin_pull_low` is 0 on the next cycle.
- R11: Each time the test wave is newly granted, it starts with `pin_pull_low`=0, and the first tick drives it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_bit | input | 1 | Clock stopped when 1 |
| ft_wr | input | 1 | Write strobe for the stored test bit |
| ft_wdata | input | 1 | Value written to the test bit |
| afe_bit | input | 1 | Alarm signalling on the pin enabled |
| wd_reg | input | WD_W | Watchdog register; MSB is steering (0 = pin, 1 = reset pin) |
| wdog_irq | input | 1 | Watchdog timeout request |
| alarm_irq | input | 1 | Alarm match request |
| tick_1k | input | 1 | One-cycle strobe at 1024 Hz |
| power_fail | input | 1 | Supply below the trip point |
| pin_pull_low | output | 1 | Pull-low enable for the open-drain pin |

## Verification
Faults inside the block show up at the pin within one or two cycles:
- A stale phase register appears as a wrong level on the first tick after a grant.
- A lost or spurious toggle shows as a level that does not follow the tick count.
- A wrong priority lets the wave show through while an interrupt is pending.
- A test bit that survives power-fail shows as a wave that starts later, with no new write.

The bench checks the pin on every cycle against a model built from the requirements. Because a single missed edge inverts every sample that follows, such a fault is found at the next tick.

// File: rtl/irqft_pkg.sv
package irqft_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_WDOG  = 2'd1,
        SRC_ALARM = 2'd2,
        SRC_FTEST = 2'd3
    } src_e;

    function automatic logic is_irq(input src_e s);
        return (s == SRC_WDOG) || (s == SRC_ALARM);
    endfunction
endpackage

// File: rtl/irqft_ftbit.sv
module irqft_ftbit (
    input  logic clk,
    input  logic rst,
    input  logic power_fail,
    input  logic ft_wr,
    input  logic ft_wdata,
    output logic ft_q
);
    always_ff @(posedge clk) begin
        if (rst || power_fail) ft_q <= 1'b0;
        else if (ft_wr)        ft_q <= ft_wdata;
    end

    // R9: power loss clears the stored test bit
    assert_pf_clears_R9: assert property (@(posedge clk) disable iff (rst)
        power_fail |=> !ft_q);
endmodule

// File: rtl/irqft_arb.sv
module irqft_arb
    import irqft_pkg::*;
#(
    parameter int WD_W = 8
) (
    input  logic            ft_q,
    input  logic            stop_bit,
    input  logic            afe_bit,
    input  logic [WD_W-1:0] wd_reg,
    input  logic            wdog_irq,
    input  logic            alarm_irq,
    output src_e            grant
);
    localparam int STEER = WD_W - 1;

    logic wd_to_pin, wd_clear, test_ok;

    always_comb begin
        wd_to_pin = !wd_reg[STEER];
        wd_clear  = (wd_reg == '0);
        test_ok   = !stop_bit && ft_q && !afe_bit && (wd_reg[STEER] || wd_clear);
        if (wdog_irq && wd_to_pin)    grant = SRC_WDOG;
        else if (alarm_irq && afe_bit) grant = SRC_ALARM;
        else if (test_ok)             grant = SRC_FTEST;
        else                          grant = SRC_IDLE;
    end
endmodule

// File: rtl/irqft_square.sv
module irqft_square (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic phase_d
);
    logic phase_q;

    always_comb phase_d = en ? (tick ? !phase_q : phase_q) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= phase_d;
    end

    // R2: a tick while enabled flips the phase
    assert_tick_flips_R2: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (phase_q != $past(phase_q)));
    // R11: a disabled generator rests at the released level
    assert_idle_phase_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> !phase_q);
endmodule

// File: rtl/irqft_pin_arbiter.sv
module irqft_pin_arbiter
    import irqft_pkg::*;
#(
    parameter int WD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stop_bit,
    input  logic            ft_wr,
    input  logic            ft_wdata,
    input  logic            afe_bit,
    input  logic [WD_W-1:0] wd_reg,
    input  logic            wdog_irq,
    input  logic            alarm_irq,
    input  logic            tick_1k,
    input  logic            power_fail,
    output logic            pin_pull_low
);
    localparam int STEER = WD_W - 1;

    logic ft_q, phase_d;
    src_e grant;

    irqft_ftbit u_ftbit (
        .clk(clk), .rst(rst), .power_fail(power_fail),
        .ft_wr(ft_wr), .ft_wdata(ft_wdata), .ft_q(ft_q)
    );

    irqft_arb #(.WD_W(WD_W)) u_arb (
        .ft_q(ft_q), .stop_bit(stop_bit), .afe_bit(afe_bit), .wd_reg(wd_reg),
        .wdog_irq(wdog_irq), .alarm_irq(alarm_irq), .grant(grant)
    );

    irqft_square u_sq (
        .clk(clk), .rst(rst), .en(grant == SRC_FTEST), .tick(tick_1k),
        .phase_d(phase_d)
    );

    always_ff @(posedge clk) begin
        if (rst)                 pin_pull_low <= 1'b0;
        else if (is_irq(grant))  pin_pull_low <= 1'b1;
        else if (grant == SRC_FTEST) pin_pull_low <= phase_d;
        else                     pin_pull_low <= 1'b0;
    end

    // R6: watchdog routed to the pin holds it low
    assert_wdog_low_R6: assert property (@(posedge clk) disable iff (rst)
        (wdog_irq && !wd_reg[STEER]) |=> pin_pull_low);
    // R7: enabled alarm holds the pin low
    assert_alarm_low_R7: assert property (@(posedge clk) disable iff (rst)
        (alarm_irq && afe_bit) |=> pin_pull_low);
    // R3: stopped clock with no routed interrupt releases the pin
    assert_stop_release_R3: assert property (@(posedge clk) disable iff (rst)
        (stop_bit && !(wdog_irq && !wd_reg[STEER]) && !(alarm_irq && afe_bit))
        |=> !pin_pull_low);
    // R1: released right after reset
    assert_reset_release_R1: assert property (@(posedge clk)
        rst |=> !pin_pull_low);
endmodule

// File: tb/sim_irqft_pin_arbiter.sv
module sim_irqft_pin_arbiter;
    localparam int WD_W = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic stop_bit = 0, ft_wr = 0, ft_wdata = 0, afe_bit = 0;
    logic [WD_W-1:0] wd_reg = '0;
    logic wdog_irq = 0, alarm_irq = 0, tick_1k = 0, power_fail = 0;
    logic pin_pull_low;

    int checks = 0, failures = 0, cycles = 0;
    logic ft_m = 0, ph_m = 0, pin_m = 0;

    always #2.5 clk = !clk;

    irqft_pin_arbiter #(.WD_W(WD_W)) u0 (
        .clk(clk), .rst(rst), .stop_bit(stop_bit), .ft_wr(ft_wr),
        .ft_wdata(ft_wdata), .afe_bit(afe_bit), .wd_reg(wd_reg),
        .wdog_irq(wdog_irq), .alarm_irq(alarm_irq), .tick_1k(tick_1k),
        .power_fail(power_fail), .pin_pull_low(pin_pull_low)
    );

    function automatic logic irq_routed();
        return (wdog_irq && !wd_reg[WD_W-1]) || (alarm_irq && afe_bit);
    endfunction

    function automatic logic test_granted(input logic ft);
        return !irq_routed() && !stop_bit && ft && !afe_bit &&
               (wd_reg[WD_W-1] || wd_reg == '0);
    endfunction

    function automatic string auto_tag();
        if (wdog_irq && !wd_reg[WD_W-1]) return "R6";
        if (alarm_irq && afe_bit)        return "R7";
        if (test_granted(ft_m))          return "R2";
        return "R10";
    endfunction

    task automatic chk(input string tag, input logic exp);
        checks++;
        if (pin_pull_low !== exp) begin
            failures++;
            $display("FAIL %s pin_pull_low=%0b expected=%0b", tag, pin_pull_low, exp);
        end
    endtask

    // Advance one clock with current inputs, update the model, check.
    task automatic step(input string tag);
        logic g;
        string t;
        t = (tag == "") ? auto_tag() : tag;
        g = test_granted(ft_m);
        @(posedge clk);
        if (rst) begin
            pin_m = 0; ph_m = 0; ft_m = 0;
        end else begin
            ph_m  = g ? (tick_1k ? !ph_m : ph_m) : 1'b0;
            pin_m = irq_routed() ? 1'b1 : (g ? ph_m : 1'b0);
            if (power_fail) ft_m = 0;
            else if (ft_wr) ft_m = ft_wdata;
        end
        @(negedge clk);
        chk(t, pin_m);
    endtask

    task automatic ex(input string tag, input logic exp);
        step(tag);
        checks++;
        if (pin_m !== exp) begin
            failures++;
            $display("FAIL %s model=%0b expected=%0b", tag, pin_m, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1");
        rst = 0;
        chk("R1", 1'b0);
        // R1: stored bit starts cleared, so a granted setup without a write stays released
        tick_1k = 1;
        ex("R1", 1'b0);
        // enable test: write bit, wd cleared
        ft_wr = 1; ft_wdata = 1; tick_1k = 0;
        ex("R10", 1'b0);
        ft_wr = 0;
        // R11: first tick pulls low, R2 toggling
        tick_1k = 1; ex("R11", 1'b1);
        tick_1k = 0; ex("R2", 1'b1);
        tick_1k = 1; ex("R2", 1'b0);
        tick_1k = 1; ex("R2", 1'b1);
        // R3: stop releases
        stop_bit = 1; ex("R3", 1'b0);
        stop_bit = 0; tick_1k = 0; ex("R11", 1'b0);
        tick_1k = 1; ex("R11", 1'b1);
        // R4: afe denies
        afe_bit = 1; ex("R4", 1'b0);
        afe_bit = 0; tick_1k = 0; ex("R10", 1'b0);
        // R5: wd nonzero steered to pin denies; steered to reset allows
        wd_reg = 8'h0E; tick_1k = 1; ex("R5", 1'b0);
        wd_reg = 8'h8E; ex("R5", 1'b1);
        // R8: watchdog steered to reset does not touch pin
        wdog_irq = 1; ex("R8", 1'b0);
        ex("R8", 1'b1);
        // R6: watchdog routed to pin overrides wave with wd_reg all zeros
        wd_reg = 8'h00; ex("R6", 1'b1);
        ex("R6", 1'b1);
        ex("R6", 1'b1);
        wdog_irq = 0; tick_1k = 1; ex("R11", 1'b1);
        // R7: alarm
        alarm_irq = 1; afe_bit = 1; ex("R7", 1'b1);
        tick_1k = 0; ex("R7", 1'b1);
        alarm_irq = 0; ex("R4", 1'b0);
        afe_bit = 0;
        // R9: power fail beats a set write
        power_fail = 1; ft_wr = 1; ft_wdata = 1; tick_1k = 1; ex("R9", 1'b1);
        power_fail = 0; ft_wr = 0; ex("R9", 1'b0);
        ex("R9", 1'b0);
        // random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            tick_1k    = (r[1:0] == 2'd0);
            stop_bit   = (r[6:2] == 5'd0);
            afe_bit    = (r[11:7] == 5'd0);
            alarm_irq  = (r[14:12] == 3'd0);
            wdog_irq   = (r[18:15] == 4'd0);
            power_fail = (r[25:19] == 7'd0);
            ft_wr      = (r[29:26] == 4'd0);
            ft_wdata   = r[30];
            if (r[31]) begin
                case ($urandom % 4)
                    0: wd_reg = 8'h00;
                    1: wd_reg = 8'h8E;
                    2: wd_reg = 8'h0E;
                    default: wd_reg = 8'($urandom);
                endcase
            end
            step("");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule